// File: doc/BRIEF.md
# Parallel Prefix Adder (Generate/Alive Form)

This block adds two unsigned operands of a parameterised width together with a single carry-in. It produces the sum and a carry-out within one combinational path. Each bit position first forms a generate flag (both operands one) and an alive flag (at least one operand one). A regular prefix network then merges these pairs over spans that double in length at every level. The network has a fan-out of two.

The carry-in is handled as an extra position placed below bit 0. As a result, the carry into bit i is the group generate of the span that runs from that extra position up to bit i-1. There are log2(WIDTH)+1 merge levels. At level k, each position is merged with the position 2^(k-1) below it. The sum bits come from XOR-ing each bit's propagate flag (operands differ) with its carry. The block has no clock and holds no state, so it drops into any datapath cone that needs a fast adder.

Top module: `ppa_adder`

## Requirements
- R1: When the operands share no set bit and carry_in is 0, each sum bit equals op_x[i] XOR op_y[i] and carry_out is 0.
- R2: A position where both operands are 0 stops any incoming carry. The carry into the next position is then 0.
- R3: A position where both operands are 1 creates a carry into the next position, whatever the lower bits are.
- R4: carry_in acts as a position below bit 0. With both operands all-zero, carry_in = 1 gives sum = 1 and carry_out = 0.
- R5: A carry entering a run of positions that are alive but do not generate passes through the whole run. With op_x all-ones, op_y = 0 and carry_in = 1, the result is sum = 0 and carry_out = 1.
- R6: For every operand pair and carry_in, sum equals (op_x + op_y + carry_in) mod 2^WIDTH.
- R7: carry_out equals bit WIDTH of op_x + op_y + carry_in.
- R8: The same structure gives correct results for WIDTH = 16 and WIDTH = 32 as well as the default 8. WIDTH must be a power of two, at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_x | input | WIDTH | First operand |
| op_y | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into the lowest position |
| sum | output | WIDTH | Sum modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the top position |

## Verification
Two effects can land on the same bit in the same evaluation: a carry created locally where both operands are 1, and a carry arriving from far below through a long alive run. An extreme case is the carry-in travelling the full width while an upper bit also generates. These collisions are provoked by the exhaustive sweep of the 8-bit instance over all operand pairs and both carry-in values. Directed patterns add a kill position inside an alive run and an all-ones operand with carry-in set. Each result is judged against an arithmetic sum formed in the bench at one bit wider than the operands. The 16-bit and 32-bit instances receive random operands in the same cycles.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

    // Group signals for a span of positions: generate and alive
    typedef struct packed {
        logic gen;
        logic alive;
    } span_t;

    // Merge an upper span with the adjacent (or overlapping) lower span
    function automatic span_t span_join(span_t upper, span_t lower);
        span_t res;
        res.gen   = upper.gen | (upper.alive & lower.gen);
        res.alive = upper.alive & lower.alive;
        return res;
    endfunction

    // Merge levels needed to cover WIDTH+1 positions
    function automatic int unsigned level_count(int unsigned width);
        return $clog2(width) + 1;
    endfunction

endpackage

// File: rtl/ppa_bit_cells.sv
module ppa_bit_cells
    import ppa_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0]  op_x,
    input  logic [WIDTH-1:0]  op_y,
    input  logic              carry_in,
    output span_t [WIDTH:0]   leaf,
    output logic [WIDTH-1:0]  prop
);
    // Index 0 is the carry-in position; index i+1 holds operand bit i
    assign leaf[0] = '{gen: carry_in, alive: carry_in};

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        assign leaf[i+1].gen   = op_x[i] & op_y[i];
        assign leaf[i+1].alive = op_x[i] | op_y[i];
        assign prop[i]         = op_x[i] ^ op_y[i];
    end

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            // R1
            prop_excl_chk: assert (!(prop[i] && leaf[i+1].gen))
                else $error("bit %0d both propagates and generates", i);
        end
    end

endmodule

// File: rtl/ppa_prefix_net.sv
module ppa_prefix_net
    import ppa_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  span_t [WIDTH:0]  leaf,
    output logic [WIDTH:0]   carry
);
    localparam int unsigned LEVELS = level_count(WIDTH);
    localparam int unsigned NPOS   = WIDTH + 1;

    span_t [WIDTH:0] stage [LEVELS+1];

    assign stage[0] = leaf;

    // Level lvl+1 merges each position with the one 2^lvl below it
    for (genvar lvl = 0; lvl < LEVELS; lvl++) begin : g_level
        localparam int unsigned DIST = 1 << lvl;
        for (genvar j = 0; j < NPOS; j++) begin : g_pos
            if (j >= DIST) begin : g_merge
                assign stage[lvl+1][j] = span_join(stage[lvl][j], stage[lvl][j-DIST]);
            end else begin : g_pass
                assign stage[lvl+1][j] = stage[lvl][j];
            end
        end
    end

    // Group generate spanning the carry-in position up to index j
    for (genvar j = 0; j < NPOS; j++) begin : g_out
        assign carry[j] = stage[LEVELS][j].gen;
    end

    always_comb begin
        logic run_alive;
        run_alive = 1'b1;
        for (int j = 0; j < NPOS; j++) begin
            run_alive = run_alive & leaf[j].alive;
            // R5
            span_alive_chk: assert (stage[LEVELS][j].alive == run_alive)
                else $error("final alive wrong at %0d", j);
            if (j > 0) begin
                if (!leaf[j].alive) begin
                    // R2
                    carry_kill_chk: assert (!carry[j])
                        else $error("carry not killed at %0d", j);
                end
                if (leaf[j].gen) begin
                    // R3
                    carry_gen_chk: assert (carry[j])
                        else $error("carry not generated at %0d", j);
                end
            end
        end
        // R4
        low_carry_chk: assert (carry[1] == (leaf[1].gen | (leaf[1].alive & leaf[0].gen)))
            else $error("carry into bit 1 ignores carry-in");
    end

endmodule

// File: rtl/ppa_sum_stage.sv
module ppa_sum_stage #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] prop,
    input  logic [WIDTH:0]   carry,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_xor
        assign sum[i] = prop[i] ^ carry[i];
    end
    assign carry_out = carry[WIDTH];

    always_comb begin
        if (&prop) begin
            // R5
            full_pass_chk: assert (carry_out == carry[0])
                else $error("carry did not cross a full propagate run");
        end
    end

endmodule

// File: rtl/ppa_adder.sv
module ppa_adder
    import ppa_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] op_x,
    input  logic [WIDTH-1:0] op_y,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    // R8
    if (WIDTH < 2 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
        $error("WIDTH must be a power of two and at least 2");
    end

    span_t [WIDTH:0]  leaf;
    logic [WIDTH-1:0] prop;
    logic [WIDTH:0]   carry;

    ppa_bit_cells #(.WIDTH(WIDTH)) u_cells (
        .op_x     (op_x),
        .op_y     (op_y),
        .carry_in (carry_in),
        .leaf     (leaf),
        .prop     (prop)
    );

    ppa_prefix_net #(.WIDTH(WIDTH)) u_net (
        .leaf  (leaf),
        .carry (carry)
    );

    ppa_sum_stage #(.WIDTH(WIDTH)) u_sum (
        .prop      (prop),
        .carry     (carry),
        .sum       (sum),
        .carry_out (carry_out)
    );

    always_comb begin
        logic [WIDTH:0] ref_total;
        ref_total = {1'b0, op_x} + {1'b0, op_y} + {{WIDTH{1'b0}}, carry_in};
        // R6
        sum_value_chk: assert (sum == ref_total[WIDTH-1:0])
            else $error("sum mismatch");
        // R7
        carry_out_chk: assert (carry_out == ref_total[WIDTH])
            else $error("carry_out mismatch");
    end

endmodule

// File: tb/tb_ppa_adder.sv
module tb_ppa_adder;

    typedef struct {
        logic [32:0] exp;
        string       tag;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [7:0]  x8,  y8;  logic c8;  logic [7:0]  s8;  logic co8;
    logic [15:0] x16, y16; logic c16; logic [15:0] s16; logic co16;
    logic [31:0] x32, y32; logic c32; logic [31:0] s32; logic co32;

    ppa_adder #(.WIDTH(8)) dut (
        .op_x(x8), .op_y(y8), .carry_in(c8), .sum(s8), .carry_out(co8));
    ppa_adder #(.WIDTH(16)) dut16 (
        .op_x(x16), .op_y(y16), .carry_in(c16), .sum(s16), .carry_out(co16));
    ppa_adder #(.WIDTH(32)) dut32 (
        .op_x(x32), .op_y(y32), .carry_in(c32), .sum(s32), .carry_out(co32));

    item_t q8[$], q16[$], q32[$];
    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic done = 1'b0;

    task automatic compare(int w, logic [32:0] got, item_t it);
        checks++;
        if (got !== it.exp) begin
            failures++;
            $display("FAIL %s w=%0d actual=%h expected=%h", it.tag, w, got, it.exp);
        end
    endtask

    // Driver: apply one vector to each instance and queue its expected value
    task automatic step(logic [7:0] a8, logic [7:0] b8, logic ci8,
                        logic [15:0] a16, logic [15:0] b16, logic ci16,
                        logic [31:0] a32, logic [31:0] b32, logic ci32,
                        string tg);
        @(negedge clk);
        x8 = a8;   y8 = b8;   c8 = ci8;
        x16 = a16; y16 = b16; c16 = ci16;
        x32 = a32; y32 = b32; c32 = ci32;
        q8.push_back('{33'(a8) + 33'(b8) + 33'(ci8), tg});
        q16.push_back('{33'(a16) + 33'(b16) + 33'(ci16), tg});
        q32.push_back('{33'(a32) + 33'(b32) + 33'(ci32), tg});
    endtask

    // Monitor: results of the vector applied at the previous falling edge
    always @(posedge clk) begin
        if (!rst) begin
            if (q8.size() > 0)  compare(8,  {24'b0, co8,  s8},  q8.pop_front());
            if (q16.size() > 0) compare(16, {16'b0, co16, s16}, q16.pop_front());
            if (q32.size() > 0) compare(32, {co32, s32},        q32.pop_front());
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > 190000) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        x8 = '0; y8 = '0; c8 = 1'b0;
        x16 = '0; y16 = '0; c16 = 1'b0;
        x32 = '0; y32 = '0; c32 = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R6 reset-state: zero operands give zero result
        step(8'h00, 8'h00, 1'b0, 16'h0, 16'h0, 1'b0, 32'h0, 32'h0, 1'b0, "R6 zero after reset");
        // R1: disjoint operands, no carries
        step(8'hA5, 8'h5A, 1'b0, 16'hA5A5, 16'h5A5A, 1'b0,
             32'hF0F0_0F0F, 32'h0F0F_F0F0, 1'b0, "R1 disjoint bits");
        // R2: a killed position inside an alive run stops the carry
        step(8'hF7, 8'h00, 1'b1, 16'hFF7F, 16'h0000, 1'b1,
             32'hFFFF_7FFF, 32'h0, 1'b1, "R2 kill stops carry");
        // R3: both operands one create a carry
        step(8'h10, 8'h10, 1'b0, 16'h0100, 16'h0100, 1'b0,
             32'h0001_0000, 32'h0001_0000, 1'b0, "R3 generate");
        // R4: carry-in as the lowest position
        step(8'h00, 8'h00, 1'b1, 16'h0, 16'h0, 1'b1, 32'h0, 32'h0, 1'b1, "R4 carry-in only");
        // R5: carry crosses an all-alive run
        step(8'hFF, 8'h00, 1'b1, 16'hFFFF, 16'h0, 1'b1,
             32'hFFFF_FFFF, 32'h0, 1'b1, "R5 full carry pass");
        // R7: top-bit generate gives carry_out
        step(8'h80, 8'h80, 1'b0, 16'h8000, 16'h8000, 1'b0,
             32'h8000_0000, 32'h8000_0000, 1'b0, "R7 carry_out from top");
        // R7: maximal operands with carry-in
        step(8'hFF, 8'hFF, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1,
             32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R7 all ones");

        // R6 exhaustive 8-bit sweep; R8 random wider instances alongside
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                for (int c = 0; c < 2; c++) begin
                    step(8'(a), 8'(b), 1'(c),
                         16'($urandom), 16'($urandom), 1'($urandom),
                         $urandom, $urandom, 1'($urandom),
                         "R6/R8 sweep");
                end
            end
        end

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule